// File: doc/BRIEF.md
# Sync-Timed Video to AXI4-Stream Bridge

This block takes parallel pixel video that is framed by sync pulses, blanking levels and a data-valid strobe, all on one pixel clock, and turns it into an AXI4-Stream video master. Blanking and sync intervals produce no beats. Only active pixels are carried. The bridge attaches two sideband flags that replace the timing signals downstream: `m_tuser` marks the first pixel of a frame and `m_tlast` marks the final pixel of each line.

The `enable` input is meant to be driven by the locked indication of an external timing detector. While it is low, nothing new enters the stream. After it rises, the bridge waits for a vertical marker before it passes any beat, so a frame is never started part way through. A 16-entry FIFO absorbs `m_tready` backpressure. If the FIFO overflows, the bridge discards the rest of that frame and resynchronises on the next vertical marker. If the pixel clock is lost, the bridge must be reset. Otherwise a partial frame can leak out once lock returns.

The control path is a four-state machine:
- OFF: disabled.
- SEEK: waiting for the first frame after enable.
- RUN: streaming.
- DROP: discarding after an overflow.

Its transitions are:
- Any state goes to OFF when `enable` is low.
- OFF goes to SEEK when `enable` is high.
- SEEK goes to RUN on a vertical edge.
- RUN goes to DROP when a pixel finds the FIFO full.
- DROP goes to RUN on a vertical edge.

The parameter `TIMING_SET` selects which timing signals are honoured:
- 0: syncs only.
- 1: blanks only.
- 2 (default): all four timing signals.

Top module: `vid2axis_bridge`

## Requirements
- R1: While in RUN with room in the FIFO, every active pixel appears exactly once on `m_tdata`, in arrival order.
- R2: `m_tlast` is 1 on a beat exactly when the pixel was active and the input on the following clock is not active.
- R3: The vertical marker is a rising edge of (vsync OR vblank). `m_tuser` is 1 only on the first active pixel after such an edge.
- R4: With the default timing set, a pixel is active only when data valid is 1 and vsync, hsync, vblank and hblank are all 0. Data valid asserted during blanking produces no beat.
- R5: After `enable` rises, no beat is accepted until a vertical edge has been seen. The first beat accepted after that edge carries `m_tuser`.
- R6: While `enable` is 0, no pixel enters the FIFO. A frame interrupted by `enable` falling is not resumed until a later vertical edge.
- R7: A pixel that finds the FIFO full (16 entries, with full judged before any same-cycle pop) is lost, together with the rest of its frame, until the next vertical edge. The buffered beats are still delivered.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata`, `m_tlast` and `m_tuser` hold their values.
- R9: During and right after a synchronous active-high reset, `m_tvalid` is 0, the FIFO is empty and the state is OFF.
- R10: `m_tvalid` is 1 exactly when the FIFO holds a beat. An accepted pixel sampled at clock edge k is written into the FIFO at edge k+1 and can be visible from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Timing-lock enable; low blocks the stream |
| vid_data | input | DATA_W | Parallel pixel value |
| vid_de | input | 1 | Data-valid strobe |
| vid_vsync | input | 1 | Vertical sync, active high |
| vid_hsync | input | 1 | Horizontal sync, active high |
| vid_vblank | input | 1 | Vertical blanking, active high |
| vid_hblank | input | 1 | Horizontal blanking, active high |
| m_tdata | output | DATA_W | Stream pixel data |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | End of line flag |
| m_tuser | output | 1 | Start of frame flag |

## Verification
The hardest situation to reach is the overflow path. It needs a full frame presented with `m_tready` held low, so that the seventeenth pixel meets a full FIFO. Recovery then depends on the FIFO draining during the next vertical blanking before that frame's active lines begin. The bench holds ready low for one entire frame and releases it exactly at the start of the next frame. A behavioural queue model follows the state on every clock.

Two other hard cases are `enable` rising in the middle of a frame and `enable` falling in the middle of a frame. The bench drives both at chosen line boundaries. It also drives a frame in which data valid leaks into both blanking intervals.

// File: rtl/vid2axis_pkg.sv
package vid2axis_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SEEK = 2'd1,
        ST_RUN  = 2'd2,
        ST_DROP = 2'd3
    } gate_state_t;

    localparam int TS_SYNC  = 0;
    localparam int TS_BLANK = 1;
    localparam int TS_BOTH  = 2;

endpackage

// File: rtl/vid2axis_capture.sv
module vid2axis_capture
    import vid2axis_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int TIMING_SET = TS_BOTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] vid_data,
    input  logic              vid_de,
    input  logic              vid_vsync,
    input  logic              vid_hsync,
    input  logic              vid_vblank,
    input  logic              vid_hblank,
    output logic              vert_edge,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic              pix_eol,
    output logic              pix_sof
);

    logic vert;
    logic horiz;
    logic active_in;
    logic vert_q;
    logic first_pend;
    logic hold_v;
    logic hold_s;
    logic [DATA_W-1:0] hold_d;

    generate
        if (TIMING_SET == TS_SYNC) begin : g_sync
            assign vert  = vid_vsync;
            assign horiz = vid_hsync;
        end else if (TIMING_SET == TS_BLANK) begin : g_blank
            assign vert  = vid_vblank;
            assign horiz = vid_hblank;
        end else begin : g_both
            assign vert  = vid_vsync | vid_vblank;
            assign horiz = vid_hsync | vid_hblank;
        end
    endgenerate

    always_comb begin
        active_in = vid_de & ~vert & ~horiz;
        vert_edge = vert & ~vert_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vert_q     <= 1'b0;
            first_pend <= 1'b0;
            hold_v     <= 1'b0;
            hold_s     <= 1'b0;
            hold_d     <= '0;
        end else begin
            vert_q <= vert;
            hold_v <= active_in;
            if (active_in) begin
                hold_d <= vid_data;
                hold_s <= first_pend;
            end
            if (vert_edge) begin
                first_pend <= 1'b1;
            end else if (active_in) begin
                first_pend <= 1'b0;
            end
        end
    end

    // The held pixel is the end of its line when the present input is no longer active.
    always_comb begin
        pix_valid = hold_v;
        pix_data  = hold_d;
        pix_sof   = hold_s;
        pix_eol   = ~active_in;
    end

    // R4
    beat_follows_active_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(active_in));

endmodule

// File: rtl/vid2axis_gate.sv
module vid2axis_gate
    import vid2axis_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        vert_edge,
    input  logic        pix_valid,
    input  logic        fifo_full,
    output logic        push,
    output gate_state_t state
);

    gate_state_t state_next;

    always_comb begin
        state_next = state;
        if (!enable) begin
            state_next = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  state_next = ST_SEEK;
                ST_SEEK: if (vert_edge) state_next = ST_RUN;
                ST_RUN:  if (pix_valid && fifo_full) state_next = ST_DROP;
                ST_DROP: if (vert_edge) state_next = ST_RUN;
                default: state_next = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
        end else begin
            state <= state_next;
        end
    end

    always_comb begin
        push = 1'b0;
        unique case (state)
            ST_RUN:  push = pix_valid & ~fifo_full;
            ST_OFF, ST_SEEK, ST_DROP: push = 1'b0;
            default: push = 1'b0;
        endcase
    end

    // R6
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state == ST_OFF));

    // R5
    run_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) != ST_RUN) |-> $past(vert_edge));

endmodule

// File: rtl/vid2axis_fifo.sv
module vid2axis_fifo #(
    parameter int WIDTH = 26,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    output logic             full,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] DEPTH_C = (AW + 1)'(DEPTH);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   count;
    logic          pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_C) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full      = (count == DEPTH_C);
        out_valid = (count != '0);
        pop       = out_valid & out_ready;
        out_data  = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    full_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

endmodule

// File: rtl/vid2axis_bridge.sv
module vid2axis_bridge
    import vid2axis_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int FIFO_DEPTH = 16,
    parameter int TIMING_SET = TS_BOTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DATA_W-1:0] vid_data,
    input  logic              vid_de,
    input  logic              vid_vsync,
    input  logic              vid_hsync,
    input  logic              vid_vblank,
    input  logic              vid_hblank,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast,
    output logic              m_tuser
);

    localparam int BEAT_W = DATA_W + 2;

    logic              vert_edge;
    logic              pix_valid;
    logic [DATA_W-1:0] pix_data;
    logic              pix_eol;
    logic              pix_sof;
    logic              push;
    logic              fifo_full;
    gate_state_t       state;
    logic [BEAT_W-1:0] in_beat;
    logic [BEAT_W-1:0] out_beat;

    vid2axis_capture #(
        .DATA_W     (DATA_W),
        .TIMING_SET (TIMING_SET)
    ) u_capture (
        .clk        (clk),
        .rst        (rst),
        .vid_data   (vid_data),
        .vid_de     (vid_de),
        .vid_vsync  (vid_vsync),
        .vid_hsync  (vid_hsync),
        .vid_vblank (vid_vblank),
        .vid_hblank (vid_hblank),
        .vert_edge  (vert_edge),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .pix_eol    (pix_eol),
        .pix_sof    (pix_sof)
    );

    vid2axis_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .vert_edge (vert_edge),
        .pix_valid (pix_valid),
        .fifo_full (fifo_full),
        .push      (push),
        .state     (state)
    );

    assign in_beat = {pix_sof, pix_eol, pix_data};

    vid2axis_fifo #(
        .WIDTH (BEAT_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (in_beat),
        .full      (fifo_full),
        .out_valid (m_tvalid),
        .out_ready (m_tready),
        .out_data  (out_beat)
    );

    always_comb begin
        m_tdata = out_beat[DATA_W-1:0];
        m_tlast = out_beat[DATA_W];
        m_tuser = out_beat[DATA_W+1];
    end

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!m_tvalid && state == ST_OFF));

endmodule

// File: tb/vid2axis_bridge_bench.sv
module vid2axis_bridge_bench;

    localparam int DW = 24;
    localparam int W  = 8;
    localparam int LINES = 4;
    localparam int HB = 6;
    localparam int VBL = 2;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [DW-1:0] vid_data = '0;
    logic          vid_de = 1'b0;
    logic          vid_vsync = 1'b0;
    logic          vid_hsync = 1'b0;
    logic          vid_vblank = 1'b0;
    logic          vid_hblank = 1'b0;
    logic [DW-1:0] m_tdata;
    logic          m_tvalid;
    logic          m_tready = 1'b1;
    logic          m_tlast;
    logic          m_tuser;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int rdy_cnt = 0;
    int pix_ctr = 1;
    int n_beats = 0;
    int n_last = 0;
    int n_user = 0;

    always #2.5 clk = ~clk;

    vid2axis_bridge u_vid2axis_bridge (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .vid_data   (vid_data),
        .vid_de     (vid_de),
        .vid_vsync  (vid_vsync),
        .vid_hsync  (vid_hsync),
        .vid_vblank (vid_vblank),
        .vid_hblank (vid_hblank),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tlast    (m_tlast),
        .m_tuser    (m_tuser)
    );

    // ready pattern: 0 always, 1 never, 2 two of every three cycles
    always @(posedge clk) begin
        #1;
        rdy_cnt = rdy_cnt + 1;
        case (rdy_mode)
            0: m_tready = 1'b1;
            1: m_tready = 1'b0;
            default: m_tready = (rdy_cnt % 3) != 0;
        endcase
    end

    // behavioural reference: 0 off, 1 seek, 2 run, 3 drop
    logic [DW+1:0] q[$];
    int            m_st = 0;
    bit            m_vprev = 0;
    bit            m_first = 0;
    bit            m_hv = 0;
    bit            m_hs = 0;
    logic [DW-1:0] m_hd = '0;

    always @(posedge clk) begin
        bit act, vrt, vedge, full, popping;
        if (rst) begin
            q.delete();
            m_st = 0; m_vprev = 0; m_first = 0; m_hv = 0; m_hs = 0; m_hd = '0;
        end else begin
            act   = vid_de && !vid_vsync && !vid_hsync && !vid_vblank && !vid_hblank;
            vrt   = vid_vsync || vid_vblank;
            vedge = vrt && !m_vprev;
            full  = (q.size() == DEPTH);
            popping = (q.size() > 0) && m_tready;
            if (popping) void'(q.pop_front());
            if (m_hv && m_st == 2 && !full) q.push_back({m_hs, !act, m_hd});
            if (!enable) m_st = 0;
            else if (m_st == 0) m_st = 1;
            else if (m_st == 1 && vedge) m_st = 2;
            else if (m_st == 2 && m_hv && full) m_st = 3;
            else if (m_st == 3 && vedge) m_st = 2;
            if (act) begin m_hd = vid_data; m_hs = m_first; end
            m_hv = act;
            if (vedge) m_first = 1; else if (act) m_first = 0;
            m_vprev = vrt;
        end
    end

    bit            p_stall = 0;
    logic [DW+1:0] p_beat;

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (m_tvalid !== (q.size() > 0)) begin
                errors++;
                $display("FAIL R10 tvalid actual %0b expected %0b", m_tvalid, q.size() > 0);
            end else if (m_tvalid) begin
                checks++;
                if (m_tdata !== q[0][DW-1:0]) begin
                    errors++;
                    $display("FAIL R1 tdata actual %0h expected %0h", m_tdata, q[0][DW-1:0]);
                end
                if (m_tlast !== q[0][DW]) begin
                    errors++;
                    $display("FAIL R2 tlast actual %0b expected %0b", m_tlast, q[0][DW]);
                end
                if (m_tuser !== q[0][DW+1]) begin
                    errors++;
                    $display("FAIL R3 tuser actual %0b expected %0b", m_tuser, q[0][DW+1]);
                end
            end
            if (p_stall) begin
                checks++;
                if (!m_tvalid || {m_tuser, m_tlast, m_tdata} !== p_beat) begin
                    errors++;
                    $display("FAIL R8 held beat actual %0h/%0b expected %0h/1",
                             {m_tuser, m_tlast, m_tdata}, m_tvalid, p_beat);
                end
            end
            p_stall = m_tvalid && !m_tready;
            p_beat  = {m_tuser, m_tlast, m_tdata};
            if (m_tvalid && m_tready) begin
                n_beats++;
                n_last += int'(m_tlast);
                n_user += int'(m_tuser);
            end
        end
    end

    task automatic drive(input bit de, input bit hs, input bit hb, input bit vs, input bit vb,
                         input logic [DW-1:0] d);
        @(posedge clk);
        #1;
        vid_de = de; vid_hsync = hs; vid_hblank = hb;
        vid_vsync = vs; vid_vblank = vb; vid_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, '0);
    endtask

    task automatic frame(input int en_line, input int off_line, input bit leak);
        for (int vl = 0; vl < VBL; vl++)
            for (int c = 0; c < W + HB; c++)
                drive(leak && c < 4, c == 9 || c == 10, c >= W, vl == 0 && c >= 2 && c < 6, 1'b1,
                      24'hFFFFFF);
        for (int ln = 0; ln < LINES; ln++)
            for (int c = 0; c < W + HB; c++) begin
                drive(c < W || (leak && c < W + 2), c == 9 || c == 10, c >= W, 0, 0,
                      (c < W) ? DW'(pix_ctr) : 24'hEEEEEE);
                if (c < W) pix_ctr++;
                if (c == 0 && ln == en_line) enable = 1'b1;
                if (c == 0 && ln == off_line) enable = 1'b0;
            end
    endtask

    task automatic clear_counts();
        n_beats = 0; n_last = 0; n_user = 0;
    endtask

    task automatic expect_counts(input string tag, input int eb, input int el, input int eu);
        checks++;
        if (n_beats != eb || n_last != el || n_user != eu) begin
            errors++;
            $display("FAIL %s beats/tlast/tuser actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, n_beats, n_last, n_user, eb, el, eu);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(5);
        @(negedge clk);
        checks++;
        if (m_tvalid !== 1'b0) begin
            errors++;
            $display("FAIL R9 tvalid in reset actual %0b expected 0", m_tvalid);
        end
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        checks++;
        if (m_tvalid !== 1'b0) begin
            errors++;
            $display("FAIL R9 tvalid after reset actual %0b expected 0", m_tvalid);
        end

        // R6: disabled for a whole frame
        clear_counts(); frame(-1, -1, 0); idle(4);
        expect_counts("R6 disabled frame", 0, 0, 0);

        // R5: enable rises mid frame, nothing until next frame
        clear_counts(); frame(1, -1, 0); idle(4);
        expect_counts("R5 mid-frame enable", 0, 0, 0);
        rdy_mode = 2;
        clear_counts(); frame(-1, -1, 0); frame(-1, -1, 0); idle(30);
        expect_counts("R5 R1 R2 R3 two frames", 2 * W * LINES, 2 * LINES, 2);

        // R7: overflow with ready held low through a frame
        rdy_mode = 1;
        clear_counts(); frame(-1, -1, 0);
        rdy_mode = 0;
        frame(-1, -1, 0); idle(30);
        expect_counts("R7 overflow", DEPTH + W * LINES, DEPTH / W + LINES, 2);

        // R4: data valid leaking into blanking
        rdy_mode = 2;
        clear_counts(); frame(-1, -1, 1); idle(30);
        expect_counts("R4 leak into blanking", W * LINES, LINES, 1);

        // R6: disable mid frame, then re-enable before a full frame
        rdy_mode = 0;
        clear_counts(); frame(-1, 2, 0); idle(4);
        enable = 1'b1; idle(4);
        frame(-1, -1, 0); idle(30);
        expect_counts("R6 disable mid frame", 2 * W + W * LINES, 2 + LINES, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule